// File: doc/BRIEF.md
# Integer ALU Execute Stage for a 64-bit Packet Virtual Machine

This block is the arithmetic and logic execute stage of a register-based packet virtual machine. Each request carries a 4-bit operation selector, a 16-bit instruction offset field, a width class flag, the current destination register value, and a source operand. The source operand is either a full register value or a 32-bit immediate. One clock later the block returns the new destination value with a valid strobe.

The offset field picks a variant of some operations. On divide and modulo it switches from unsigned to signed arithmetic. On move it asks for a sign-extending move from a narrower source. Division and modulo by zero give defined results, so no trap path is needed. A selector and offset pair that names no operation raises an illegal-op flag and passes the destination through unchanged.

Top module: `pvm_alu`

## Requirements
- R1: A request presented with `in_valid` high produces `res_valid` high with its result exactly one clock later. `res_valid` is low in every cycle that does not follow a request. Reset clears `res_valid`, `res_illegal` and `res_data` to zero.
- R2: Selector values are: 0x0 add, 0x1 subtract, 0x2 multiply, 0x3 divide, 0x4 or, 0x5 and, 0x6 left shift, 0x7 logical right shift, 0x8 negate, 0x9 modulo, 0xA xor, 0xB move, 0xC arithmetic right shift. Add, subtract and multiply wrap at the operating width.
- R3: With `use_imm` high, the source is the immediate. In 64-bit class (`is_wide`=1) the immediate is sign-extended to 64 bits, also for unsigned divide and modulo. In 32-bit class it is taken as a 32-bit value.
- R4: Every legal 32-bit class result has bits 63:32 equal to zero.
- R5: The shift amount is the source ANDed with 63 in 64-bit class and with 31 in 32-bit class.
- R6: The arithmetic right shift takes its fill bit from bit 63 in 64-bit class and from bit 31 in 32-bit class.
- R7: Negate returns the two's complement of the destination and ignores the source.
- R8: Divide and modulo with offset 0 are unsigned. With offset 1 they are signed: the quotient truncates toward zero and the remainder takes the sign of the dividend.
- R9: Division by zero (signed or unsigned) returns zero. Modulo by zero returns the destination: all 64 bits in 64-bit class, or the low 32 bits with the upper 32 bits cleared in 32-bit class.
- R10: Signed division of the most negative value by -1 returns the most negative value of the operating width, and the matching signed modulo returns zero.
- R11: Move with offset 0 copies the source. Offset 8 or 16 sign-extends that many low source bits. In 64-bit class offset 32 also sign-extends the low 32 bits. The 32-bit class result keeps bits 63:32 at zero.
- R12: These requests are illegal: selectors 0xD to 0xF; a nonzero offset on any selector other than divide, modulo and move; an offset other than 0 or 1 on divide or modulo; an offset other than 0, 8, 16 or 32 on move; offset 32 on move in 32-bit class. An illegal request sets `res_illegal` high with `res_valid`, and `res_data` equals the unmodified `dst_val`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| op_sel | input | 4 | Operation selector |
| off_fld | input | 16 | Instruction offset field selecting variants |
| is_wide | input | 1 | 1 = 64-bit class, 0 = 32-bit class |
| dst_val | input | 64 | Current destination register value |
| use_imm | input | 1 | 1 = use immediate as source |
| src_reg | input | 64 | Source register value |
| imm_val | input | 32 | Immediate operand |
| res_valid | output | 1 | Result strobe, one cycle after the request |
| res_data | output | 64 | New destination value |
| res_illegal | output | 1 | Selector/offset pair was illegal |

## Verification
The only state held between requests is the output register. A fault in the variant decode therefore shows in the very next result as a wrong value or a wrong illegal flag. The stimulus puts the same operands through unsigned and signed divide and modulo, through both width classes, and through both source kinds. A fault in the signed/unsigned choice, the immediate extension or the upper-half clearing then makes two results differ that should agree, or makes two results agree that should differ. Zero divisors, the most-negative-by-minus-one case, and shift amounts above the mask bound expose faults in the guard and mask logic within one cycle of the request.

// File: rtl/pvm_alu_pkg.sv
package pvm_alu_pkg;

   typedef enum logic [3:0] {
      OP_ADD  = 4'h0,
      OP_SUB  = 4'h1,
      OP_MUL  = 4'h2,
      OP_DIV  = 4'h3,
      OP_OR   = 4'h4,
      OP_AND  = 4'h5,
      OP_LSH  = 4'h6,
      OP_RSH  = 4'h7,
      OP_NEG  = 4'h8,
      OP_MOD  = 4'h9,
      OP_XOR  = 4'hA,
      OP_MOV  = 4'hB,
      OP_ARSH = 4'hC,
      OP_RSVD = 4'hF
   } op_e;

   typedef enum logic [1:0] {
      SH_LEFT  = 2'd0,
      SH_LOGIC = 2'd1,
      SH_ARITH = 2'd2
   } shift_e;

   localparam int VARIANT_SIGNED = 1;
   localparam int MOVX_B8        = 8;
   localparam int MOVX_B16       = 16;
   localparam int MOVX_B32       = 32;

endpackage

// File: rtl/pvm_alu_src_prep.sv
module pvm_alu_src_prep #(
   parameter int DATA_W = 64,
   parameter int IMM_W  = 32
) (
   input  logic              use_imm,
   input  logic              is_wide,
   input  logic [DATA_W-1:0] src_reg,
   input  logic [IMM_W-1:0]  imm_val,
   output logic [DATA_W-1:0] src_op
);
   localparam int PAD_W = DATA_W - IMM_W;

   generate
      if (IMM_W > DATA_W) begin : g_bad_imm
         $error("pvm_alu_src_prep: IMM_W must not exceed DATA_W");
      end
   endgenerate

   logic [DATA_W-1:0] imm_sx;
   logic [DATA_W-1:0] imm_zx;

   always_comb begin
      imm_sx = {{PAD_W{imm_val[IMM_W-1]}}, imm_val};
      imm_zx = {{PAD_W{1'b0}}, imm_val};
      if (use_imm) src_op = is_wide ? imm_sx : imm_zx;
      else         src_op = src_reg;
   end
endmodule

// File: rtl/pvm_alu_shift.sv
module pvm_alu_shift #(
   parameter int DATA_W = 64
) (
   input  pvm_alu_pkg::shift_e      kind,
   input  logic                     is_wide,
   input  logic [DATA_W-1:0]        val,
   input  logic [$clog2(DATA_W)-1:0] amt,
   output logic [DATA_W-1:0]        shifted
);
   import pvm_alu_pkg::*;
   localparam int HALF_W = DATA_W / 2;

   logic [HALF_W-1:0] lo;
   logic [HALF_W-1:0] lo_res;
   logic [DATA_W-1:0] full_res;

   always_comb begin
      lo = val[HALF_W-1:0];
      unique case (kind)
         SH_LEFT: begin
            lo_res   = lo << amt;
            full_res = val << amt;
         end
         SH_LOGIC: begin
            lo_res   = lo >> amt;
            full_res = val >> amt;
         end
         default: begin
            lo_res   = $signed(lo) >>> amt;
            full_res = $signed(val) >>> amt;
         end
      endcase
      shifted = is_wide ? full_res : {{HALF_W{1'b0}}, lo_res};
   end
endmodule

// File: rtl/pvm_alu_divmod.sv
module pvm_alu_divmod #(
   parameter int DATA_W = 64
) (
   input  logic              sgn,
   input  logic              want_rem,
   input  logic [DATA_W-1:0] num,
   input  logic [DATA_W-1:0] den,
   output logic [DATA_W-1:0] out
);
   logic              num_neg, den_neg;
   logic [DATA_W-1:0] num_mag, den_mag;
   logic [DATA_W-1:0] quo_mag, rem_mag;
   logic [DATA_W-1:0] quo, rem;

   always_comb begin
      num_neg = sgn & num[DATA_W-1];
      den_neg = sgn & den[DATA_W-1];
      num_mag = num_neg ? (~num + 1'b1) : num;
      den_mag = den_neg ? (~den + 1'b1) : den;
      if (den == '0) begin
         quo_mag = '0;
         rem_mag = '0;
      end else begin
         quo_mag = num_mag / den_mag;
         rem_mag = num_mag % den_mag;
      end
      quo = (num_neg ^ den_neg) ? (~quo_mag + 1'b1) : quo_mag;
      rem = num_neg ? (~rem_mag + 1'b1) : rem_mag;
      if (den == '0) out = want_rem ? num : '0;
      else           out = want_rem ? rem : quo;
   end
endmodule

// File: rtl/pvm_alu.sv
module pvm_alu #(
   parameter int DATA_W = 64,
   parameter int IMM_W  = 32,
   parameter int OFF_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [3:0]        op_sel,
   input  logic [OFF_W-1:0]  off_fld,
   input  logic              is_wide,
   input  logic [DATA_W-1:0] dst_val,
   input  logic              use_imm,
   input  logic [DATA_W-1:0] src_reg,
   input  logic [IMM_W-1:0]  imm_val,
   output logic              res_valid,
   output logic [DATA_W-1:0] res_data,
   output logic              res_illegal
);
   import pvm_alu_pkg::*;

   localparam int HALF_W = DATA_W / 2;
   localparam int SH_W   = $clog2(DATA_W);

   generate
      if (DATA_W != 2 * IMM_W) begin : g_bad_width
         $error("pvm_alu: DATA_W must be twice IMM_W");
      end
      if (OFF_W < 6) begin : g_bad_off
         $error("pvm_alu: OFF_W too narrow for move variants");
      end
   endgenerate

   logic [DATA_W-1:0] src_op;
   logic [SH_W-1:0]   sh_amt;
   shift_e            sh_kind;
   logic [DATA_W-1:0] sh_out;
   logic              dm_sgn, dm_rem;
   logic [DATA_W-1:0] dm_num, dm_den, dm_out;
   logic              legal;
   logic [DATA_W-1:0] raw, result;
   op_e               op;

   pvm_alu_src_prep #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_src (
      .use_imm (use_imm),
      .is_wide (is_wide),
      .src_reg (src_reg),
      .imm_val (imm_val),
      .src_op  (src_op)
   );

   always_comb begin
      op      = op_e'(op_sel);
      sh_amt  = is_wide ? src_op[SH_W-1:0] : {1'b0, src_op[SH_W-2:0]};
      sh_kind = (op == OP_LSH) ? SH_LEFT : ((op == OP_RSH) ? SH_LOGIC : SH_ARITH);
   end

   pvm_alu_shift #(.DATA_W(DATA_W)) u_shift (
      .kind    (sh_kind),
      .is_wide (is_wide),
      .val     (dst_val),
      .amt     (sh_amt),
      .shifted (sh_out)
   );

   always_comb begin
      dm_sgn = (off_fld == OFF_W'(VARIANT_SIGNED));
      dm_rem = (op == OP_MOD);
      if (is_wide) begin
         dm_num = dst_val;
         dm_den = src_op;
      end else if (dm_sgn) begin
         dm_num = {{HALF_W{dst_val[HALF_W-1]}}, dst_val[HALF_W-1:0]};
         dm_den = {{HALF_W{src_op[HALF_W-1]}}, src_op[HALF_W-1:0]};
      end else begin
         dm_num = {{HALF_W{1'b0}}, dst_val[HALF_W-1:0]};
         dm_den = {{HALF_W{1'b0}}, src_op[HALF_W-1:0]};
      end
   end

   pvm_alu_divmod #(.DATA_W(DATA_W)) u_divmod (
      .sgn      (dm_sgn),
      .want_rem (dm_rem),
      .num      (dm_num),
      .den      (dm_den),
      .out      (dm_out)
   );

   always_comb begin
      legal = (off_fld == '0);
      raw   = dst_val;
      unique case (op)
         OP_ADD:  raw = dst_val + src_op;
         OP_SUB:  raw = dst_val - src_op;
         OP_MUL:  raw = dst_val * src_op;
         OP_OR:   raw = dst_val | src_op;
         OP_AND:  raw = dst_val & src_op;
         OP_XOR:  raw = dst_val ^ src_op;
         OP_NEG:  raw = ~dst_val + 1'b1;
         OP_LSH, OP_RSH, OP_ARSH: raw = sh_out;
         OP_DIV, OP_MOD: begin
            legal = (off_fld == '0) || dm_sgn;
            raw   = dm_out;
         end
         OP_MOV: begin
            unique case (off_fld)
               OFF_W'(0): raw = src_op;
               OFF_W'(MOVX_B8):
                  raw = {{(DATA_W-8){src_op[7]}}, src_op[7:0]};
               OFF_W'(MOVX_B16):
                  raw = {{(DATA_W-16){src_op[15]}}, src_op[15:0]};
               OFF_W'(MOVX_B32):
                  raw = {{(DATA_W-32){src_op[31]}}, src_op[31:0]};
               default: raw = dst_val;
            endcase
            legal = (off_fld == '0) || (off_fld == OFF_W'(MOVX_B8)) ||
                    (off_fld == OFF_W'(MOVX_B16)) ||
                    ((off_fld == OFF_W'(MOVX_B32)) && is_wide);
         end
         default: legal = 1'b0;
      endcase
      if (!legal)       result = dst_val;
      else if (is_wide) result = raw;
      else              result = {{HALF_W{1'b0}}, raw[HALF_W-1:0]};
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         res_valid   <= 1'b0;
         res_illegal <= 1'b0;
         res_data    <= '0;
      end else begin
         res_valid   <= in_valid;
         res_illegal <= in_valid & ~legal;
         if (in_valid) res_data <= result;
      end
   end
endmodule

// File: rtl/pvm_alu_chk.sv
module pvm_alu_chk #(
   parameter int DATA_W = 64,
   parameter int IMM_W  = 32,
   parameter int OFF_W  = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic [3:0]        op_sel,
   input logic [OFF_W-1:0]  off_fld,
   input logic              is_wide,
   input logic [DATA_W-1:0] dst_val,
   input logic              use_imm,
   input logic [DATA_W-1:0] src_reg,
   input logic [IMM_W-1:0]  imm_val,
   input logic              res_valid,
   input logic [DATA_W-1:0] res_data,
   input logic              res_illegal
);
   localparam int HALF_W = DATA_W / 2;

   AST_REQ_TO_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> res_valid);                                          // R1
   AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !res_valid);                                        // R1
   AST_FLAG_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      res_illegal |-> res_valid);                                       // R12
   AST_ILLEGAL_PASSTHRU: assert property (@(posedge clk) disable iff (!rst_n)
      res_illegal |-> res_data == $past(dst_val));                      // R12
   AST_NARROW_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !is_wide && op_sel == 4'h0 && off_fld == '0)
      |=> res_data[DATA_W-1:HALF_W] == '0);                            // R4
   AST_DIV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && is_wide && op_sel == 4'h3 && !use_imm && src_reg == '0 &&
       (off_fld == '0 || off_fld == OFF_W'(1)))
      |=> res_data == '0);                                              // R9
   AST_MOV_COPY: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && is_wide && op_sel == 4'hB && off_fld == '0 && !use_imm)
      |=> res_data == $past(src_reg));                                  // R11
   AST_IMM_UNUSED_NEG: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && is_wide && op_sel == 4'h8 && off_fld == '0)
      |=> res_data == ~$past(dst_val) + 1'b1);                         // R7
endmodule

bind pvm_alu pvm_alu_chk #(.DATA_W(DATA_W), .IMM_W(IMM_W), .OFF_W(OFF_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sel(op_sel),
   .off_fld(off_fld), .is_wide(is_wide), .dst_val(dst_val), .use_imm(use_imm),
   .src_reg(src_reg), .imm_val(imm_val), .res_valid(res_valid),
   .res_data(res_data), .res_illegal(res_illegal)
);

// File: tb/pvm_alu_tb.sv
`timescale 1ns/1ps
module pvm_alu_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [3:0]  op_sel = '0;
   logic [15:0] off_fld = '0;
   logic        is_wide = 1'b0;
   logic [63:0] dst_val = '0;
   logic        use_imm = 1'b0;
   logic [63:0] src_reg = '0;
   logic [31:0] imm_val = '0;
   logic        res_valid;
   logic [63:0] res_data;
   logic        res_illegal;

   int checks = 0;
   int failures = 0;
   logic [63:0] exp_q[$];
   logic        ill_q[$];
   string       tag_q[$];

   always #2 clk = ~clk;

   pvm_alu u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sel(op_sel),
      .off_fld(off_fld), .is_wide(is_wide), .dst_val(dst_val),
      .use_imm(use_imm), .src_reg(src_reg), .imm_val(imm_val),
      .res_valid(res_valid), .res_data(res_data), .res_illegal(res_illegal)
   );

   task automatic issue(input string tag, input logic [3:0] op,
                        input logic [15:0] off, input logic wide,
                        input logic [63:0] dst, input logic ui,
                        input logic [63:0] src, input logic [31:0] imm,
                        input logic [63:0] exp_d, input logic exp_i);
      @(negedge clk);
      in_valid = 1'b1; op_sel = op; off_fld = off; is_wide = wide;
      dst_val = dst; use_imm = ui; src_reg = src; imm_val = imm;
      exp_q.push_back(exp_d);
      ill_q.push_back(exp_i);
      tag_q.push_back(tag);
   endtask

   task automatic idle();
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   // Monitor / scoreboard: outputs are registered, sampled at falling edge
   always @(negedge clk) begin
      if (rst_n && res_valid) begin
         checks++;
         if (exp_q.size() == 0) begin
            failures++;
            $display("FAIL R1 unexpected result act=%h exp=none", res_data);
         end else begin
            logic [63:0] e;
            logic        ei;
            string       t;
            e  = exp_q.pop_front();
            ei = ill_q.pop_front();
            t  = tag_q.pop_front();
            if (res_data !== e || res_illegal !== ei) begin
               failures++;
               $display("FAIL %s act=%h/%b exp=%h/%b", t, res_data, res_illegal, e, ei);
            end
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired act=running exp=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      checks++;
      if (res_valid !== 1'b0 || res_illegal !== 1'b0 || res_data !== 64'h0) begin
         failures++;
         $display("FAIL R1 reset act=%b/%b/%h exp=0/0/0", res_valid, res_illegal, res_data);
      end

      // R2 basic operations and wrap
      issue("R2 add64", 4'h0, 0, 1, 64'd5, 0, 64'd7, 0, 64'd12, 0);
      issue("R2 add64 wrap", 4'h0, 0, 1, 64'hFFFF_FFFF_FFFF_FFFF, 0, 64'd1, 0, 64'h0, 0);
      issue("R2 sub64", 4'h1, 0, 1, 64'd3, 0, 64'd5, 0, 64'hFFFF_FFFF_FFFF_FFFE, 0);
      issue("R2 mul64", 4'h2, 0, 1, 64'd6, 0, 64'd7, 0, 64'd42, 0);
      issue("R2 mul64 wrap", 4'h2, 0, 1, 64'h1_0000_0000, 0, 64'h1_0000_0000, 0, 64'h0, 0);
      issue("R2 and64", 4'h5, 0, 1, 64'hF0F0, 0, 64'h3C3C, 0, 64'h3030, 0);
      issue("R2 xor64", 4'hA, 0, 1, 64'hFF00, 0, 64'h0FF0, 0, 64'hF0F0, 0);
      // R4 narrow clears upper half
      issue("R4 add32 wrap", 4'h0, 0, 0, 64'h1_FFFF_FFFF, 0, 64'd1, 0, 64'h0, 0);
      issue("R4 mov32", 4'hB, 0, 0, 64'h0, 0, 64'hAAAA_BBBB_CCCC_DDDD, 0, 64'hCCCC_DDDD, 0);
      // R3 immediate handling
      issue("R3 add64 imm -1", 4'h0, 0, 1, 64'd10, 1, 64'h0, 32'hFFFF_FFFF, 64'd9, 0);
      issue("R3 or64 imm sext", 4'h4, 0, 1, 64'h0, 1, 64'h0, 32'h8000_0000, 64'hFFFF_FFFF_8000_0000, 0);
      issue("R3 or32 imm", 4'h4, 0, 0, 64'h0, 1, 64'h0, 32'h8000_0000, 64'h8000_0000, 0);
      issue("R3 udiv64 imm sext", 4'h3, 0, 1, 64'hFFFF_FFFF, 1, 64'h0, 32'hFFFF_FFFF, 64'h0, 0);
      issue("R3 udiv32 imm", 4'h3, 0, 0, 64'hFFFF_FFFF, 1, 64'h0, 32'hFFFF_FFFF, 64'h1, 0);
      issue("R3 mov64 imm", 4'hB, 0, 1, 64'h5, 1, 64'h0, 32'h8000_0000, 64'hFFFF_FFFF_8000_0000, 0);
      // R5 shift masks
      issue("R5 lsh64 amt65", 4'h6, 0, 1, 64'd1, 0, 64'd65, 0, 64'd2, 0);
      issue("R5 lsh32 amt33", 4'h6, 0, 0, 64'd1, 0, 64'd33, 0, 64'd2, 0);
      issue("R5 lsh32 amt63", 4'h6, 0, 0, 64'd1, 0, 64'd63, 0, 64'h8000_0000, 0);
      issue("R5 rsh64 amt63", 4'h7, 0, 1, 64'h8000_0000_0000_0000, 0, 64'd63, 0, 64'd1, 0);
      // R6 arithmetic right shift fill bit
      issue("R6 arsh64", 4'hC, 0, 1, 64'h8000_0000_0000_0000, 0, 64'd4, 0, 64'hF800_0000_0000_0000, 0);
      issue("R6 arsh32 neg", 4'hC, 0, 0, 64'h8000_0000, 0, 64'd4, 0, 64'hF800_0000, 0);
      issue("R6 arsh32 bit63 ignored", 4'hC, 0, 0, 64'hFFFF_FFFF_7FFF_FFFF, 0, 64'd4, 0, 64'h07FF_FFFF, 0);
      // R7 negate
      issue("R7 neg64", 4'h8, 0, 1, 64'd1, 0, 64'h1234, 0, 64'hFFFF_FFFF_FFFF_FFFF, 0);
      issue("R7 neg32", 4'h8, 0, 0, 64'd1, 0, 64'h0, 0, 64'hFFFF_FFFF, 0);
      // R8 unsigned vs signed divide / modulo
      issue("R8 udiv64", 4'h3, 0, 1, 64'd100, 0, 64'd7, 0, 64'd14, 0);
      issue("R8 umod64", 4'h9, 0, 1, 64'd100, 0, 64'd7, 0, 64'd2, 0);
      issue("R8 udiv64 neg dividend", 4'h3, 0, 1, 64'hFFFF_FFFF_FFFF_FFF9, 0, 64'd2, 0, 64'h7FFF_FFFF_FFFF_FFFC, 0);
      issue("R8 sdiv64", 4'h3, 1, 1, 64'hFFFF_FFFF_FFFF_FFF9, 0, 64'd2, 0, 64'hFFFF_FFFF_FFFF_FFFD, 0);
      issue("R8 smod64", 4'h9, 1, 1, 64'hFFFF_FFFF_FFFF_FFF9, 0, 64'd2, 0, 64'hFFFF_FFFF_FFFF_FFFF, 0);
      issue("R8 sdiv32", 4'h3, 1, 0, 64'hFFFF_FFF9, 0, 64'd2, 0, 64'hFFFF_FFFD, 0);
      // R9 zero divisor
      issue("R9 udiv64 by 0", 4'h3, 0, 1, 64'd123, 0, 64'd0, 0, 64'd0, 0);
      issue("R9 sdiv32 by 0", 4'h3, 1, 0, 64'd123, 0, 64'd0, 0, 64'd0, 0);
      issue("R9 umod64 by 0", 4'h9, 0, 1, 64'hDEAD_BEEF_1234_5678, 0, 64'd0, 0, 64'hDEAD_BEEF_1234_5678, 0);
      issue("R9 umod32 by 0", 4'h9, 0, 0, 64'hDEAD_BEEF_1234_5678, 0, 64'd0, 0, 64'h1234_5678, 0);
      issue("R9 smod32 by 0", 4'h9, 1, 0, 64'hFFFF_FFFF_8000_0001, 0, 64'd0, 0, 64'h8000_0001, 0);
      // R10 most-negative by minus one
      issue("R10 sdiv64 min/-1", 4'h3, 1, 1, 64'h8000_0000_0000_0000, 0, 64'hFFFF_FFFF_FFFF_FFFF, 0, 64'h8000_0000_0000_0000, 0);
      issue("R10 smod64 min/-1", 4'h9, 1, 1, 64'h8000_0000_0000_0000, 0, 64'hFFFF_FFFF_FFFF_FFFF, 0, 64'h0, 0);
      issue("R10 sdiv32 min/-1", 4'h3, 1, 0, 64'h8000_0000, 1, 64'h0, 32'hFFFF_FFFF, 64'h8000_0000, 0);
      issue("R10 smod32 min/-1", 4'h9, 1, 0, 64'h8000_0000, 1, 64'h0, 32'hFFFF_FFFF, 64'h0, 0);
      // R11 sign-extending move
      issue("R11 movsx64 b8", 4'hB, 8, 1, 64'h0, 0, 64'h80, 0, 64'hFFFF_FFFF_FFFF_FF80, 0);
      issue("R11 movsx64 b16", 4'hB, 16, 1, 64'h0, 0, 64'h1234_8000, 0, 64'hFFFF_FFFF_FFFF_8000, 0);
      issue("R11 movsx64 b32", 4'hB, 32, 1, 64'h0, 0, 64'h8000_0000, 0, 64'hFFFF_FFFF_8000_0000, 0);
      issue("R11 movsx32 b8", 4'hB, 8, 0, 64'h0, 0, 64'hFF, 0, 64'hFFFF_FFFF, 0);
      issue("R11 movsx32 b16", 4'hB, 16, 0, 64'h0, 0, 64'hFFFF_7FFF, 0, 64'h7FFF, 0);
      // R12 illegal pairs
      issue("R12 add off1", 4'h0, 1, 1, 64'h1111_2222_3333_4444, 0, 64'd1, 0, 64'h1111_2222_3333_4444, 1);
      issue("R12 opcode 0xD", 4'hD, 0, 1, 64'hABCD, 0, 64'd1, 0, 64'hABCD, 1);
      issue("R12 div off2", 4'h3, 2, 1, 64'd100, 0, 64'd7, 0, 64'd100, 1);
      issue("R12 movsx32 b32", 4'hB, 32, 0, 64'h5555_6666_7777_8888, 0, 64'h8000_0000, 0, 64'h5555_6666_7777_8888, 1);
      issue("R12 mov off4", 4'hB, 4, 1, 64'h42, 0, 64'h99, 0, 64'h42, 1);
      issue("R12 legal after illegal", 4'h0, 0, 1, 64'd1, 0, 64'd1, 0, 64'd2, 0);
      idle();
      idle();
      idle();
      checks++;
      if (res_valid !== 1'b0 || exp_q.size() != 0) begin
         failures++;
         $display("FAIL R1 idle act=%b/%0d exp=0/0", res_valid, exp_q.size());
      end
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule